// File: doc/BRIEF.md
# Flash command interface controller

This block is the command front end of a parallel NOR flash device, written as a clocked model of an asynchronous microprocessor bus. The bus has a chip select, a read strobe, a write strobe, a deep-reset pin and a byte-mode select. A host writes command bytes with write strobes. Those commands pick which source feeds the read path: the memory array, the two identifier codes, or the status byte. The commands also start program and erase jobs on a small write engine. A busy counter stands in for the engine's cell timing, and the array is a small on-chip word memory.

The selected read source stays in force until a new command changes it. After a program or an erase, the block stays on status reads until the host asks for the array again. While the engine is working, every read returns status and every write is dropped.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: When `rst` or a low level on `hold_n` is released, the read source is the array. A read of word `addr` with `mode8`=0 returns that word on `dq_out` with `dq_oe`=1, and no command has to be written first. The output reflects bus inputs held for two rising clock edges.
- R2: A read needs `cs_n`=0, `rd_n`=0, `wr_n`=1 and `hold_n`=1. If `rd_n` or `cs_n` has been high for two edges, `dq_oe` is 0.
- R3: A command is taken on the clock edge that sees `wr_n` rise while `cs_n`=0 and `hold_n`=1. The command byte is `dq_in[7:0]`. A write strobe with `cs_n`=1 has no effect.
- R4: Byte FFh selects array reads and byte 90h selects identifier reads. In identifier mode, `addr[0]`=0 returns 0089h. `addr[0]`=1 returns 2274h when `BOOT_AT_TOP`=1 and 2275h when it is 0. Identifier mode lasts until FFh is written.
- R5: With `mode8`=1, identifier reads return the low byte of the code on `dq_out[7:0]` with bits 15:8 zero, and `lsb_a` is ignored. Array reads return the low byte of the word when `lsb_a`=0 and the high byte when `lsb_a`=1, always on bits 7:0 with bits 15:8 zero.
- R6: Byte 70h selects status reads. `dq_out` is {8'h00, ready, 0, erase-sequence error, program error, 4'b0000}, where bit 7 = 1 means idle.
- R7: Byte 40h followed by a second write of (target address, data word) programs the target to old AND data. Bit 4 of status is set if the data has a 1 where the old word has a 0.
- R8: Byte 20h followed by D0h erases the block of `2**BLK_AW` words that holds the address of the D0h write, setting every word in it to FFFFh. If 20h is followed by any other byte, nothing is erased and status bit 5 is set.
- R9: While a program or erase runs, reads return status with bit 7 = 0 whatever the read mode, and writes (FFh included) are dropped. After the job ends, reads keep returning status until FFh is written.
- R10: Status bits 5 and 4 stay set until byte 50h is written, which clears both.
- R11: A command byte other than FFh, 90h, 70h, 50h, 40h or 20h leaves the read mode and the array unchanged.
- R12: `hold_n`=0 forces `dq_oe` to 0 and drops writes. It also aborts a running job, so status reads ready right after release, and it clears both error bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; its rising edge takes the write |
| hold_n | input | 1 | Deep reset, active low; aborts jobs |
| mode8 | input | 1 | 1 = 8-bit data bus |
| lsb_a | input | 1 | Byte select within a word in 8-bit mode |
| addr | input | AW | Word address |
| dq_in | input | 16 | Write data; command in bits 7:0 |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Drive enable for the data bus (0 = high impedance) |

## Verification
Two events can fall into the same window. The first is a write arriving while the engine is busy: the bench writes FFh and 90h straight after a program or erase starts, then reads. It passes only if the reads still return busy status and, once the job is done, ready status rather than array or identifier data. The second is a deep reset arriving mid-erase with a read strobe held: the bench checks that `dq_oe` drops and that the next status read shows ready with the error bits cleared. Random program, read, identifier and status traffic runs against a bench model of the array and the error bits.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int DW = 16;

  localparam logic [7:0] CMD_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_PROG    = 8'h40;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;

  localparam logic [DW-1:0] MFR_CODE = 16'h0089;

  typedef enum logic [1:0] {RM_ARRAY, RM_IDENT, RM_STATUS} rmode_e;
  typedef enum logic [1:0] {CS_IDLE, CS_PROG, CS_ERASE} cstate_e;
  typedef enum logic [2:0] {W_IDLE, W_PREAD, W_PWRITE, W_ERASE, W_SETTLE} wstate_e;

  function automatic logic is_cmd(input logic [7:0] b);
    return (b == CMD_ARRAY) || (b == CMD_IDENT) || (b == CMD_STATUS) ||
           (b == CMD_CLEAR) || (b == CMD_PROG) || (b == CMD_ERASE);
  endfunction
endpackage

// File: rtl/flash_array.sv
module flash_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_n,
  input  logic          wr_evt,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          busy,
  output rmode_e        rd_mode,
  output logic          start_prog,
  output logic          start_erase,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          clr_err,
  output logic          seq_err
);
  cstate_e    st;
  logic       busy_any;
  logic [7:0] cmd;

  assign busy_any = busy || start_prog || start_erase;
  assign cmd      = wr_data[7:0];

  always_ff @(posedge clk) begin
    if (rst || !hold_n) begin
      rd_mode     <= RM_ARRAY;
      st          <= CS_IDLE;
      start_prog  <= 1'b0;
      start_erase <= 1'b0;
      clr_err     <= 1'b0;
      seq_err     <= 1'b0;
      op_addr     <= '0;
      op_data     <= '0;
    end else begin
      start_prog  <= 1'b0;
      start_erase <= 1'b0;
      clr_err     <= 1'b0;
      seq_err     <= 1'b0;
      if (wr_evt && !busy_any) begin
        unique case (st)
          CS_IDLE: begin
            case (cmd)
              CMD_ARRAY:  rd_mode <= RM_ARRAY;
              CMD_IDENT:  rd_mode <= RM_IDENT;
              CMD_STATUS: rd_mode <= RM_STATUS;
              CMD_CLEAR:  clr_err <= 1'b1;
              CMD_PROG: begin
                st      <= CS_PROG;
                rd_mode <= RM_STATUS;
              end
              CMD_ERASE: begin
                st      <= CS_ERASE;
                rd_mode <= RM_STATUS;
              end
              default: ;
            endcase
          end
          CS_PROG: begin
            start_prog <= 1'b1;
            op_addr    <= wr_addr;
            op_data    <= wr_data;
            st         <= CS_IDLE;
          end
          CS_ERASE: begin
            if (cmd == CMD_CONFIRM) begin
              start_erase <= 1'b1;
              op_addr     <= wr_addr;
            end else begin
              seq_err <= 1'b1;
            end
            st <= CS_IDLE;
          end
          default: st <= CS_IDLE;
        endcase
      end
    end
  end

  // R11: an unknown byte in the idle state keeps the read mode
  a_r11_unknown_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && !busy_any && st == CS_IDLE && !is_cmd(cmd)) |=> $stable(rd_mode));

  // R9: writes during a job change neither mode nor sequence state
  a_r9_busy_drops_writes: assert property (@(posedge clk) disable iff (rst)
    (wr_evt && busy) |=> ($stable(rd_mode) && $stable(st)));
endmodule

// File: rtl/flash_wsm.sv
module flash_wsm
  import flash_cmd_pkg::*;
#(
  parameter int AW          = 6,
  parameter int BLK_AW      = 4,
  parameter int PROG_CYCLES = 6,
  parameter int ERASE_EXTRA = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold_n,
  input  logic          start_prog,
  input  logic          start_erase,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_data,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          prog_fail,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] mem_raddr
);
  localparam int BLOCK_WORDS = 1 << BLK_AW;
  localparam int CW = $clog2(BLOCK_WORDS + PROG_CYCLES + ERASE_EXTRA + 1);

  wstate_e               st;
  logic [CW-1:0]         cnt;
  logic [CW-1:0]         lim_q;
  logic [AW-1:0]         addr_q;
  logic [DW-1:0]         data_q;
  logic [AW-BLK_AW-1:0]  blk_q;

  always_ff @(posedge clk) begin
    if (rst || !hold_n) begin
      st        <= W_IDLE;
      cnt       <= '0;
      lim_q     <= '0;
      prog_fail <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      blk_q     <= '0;
    end else begin
      prog_fail <= 1'b0;
      unique case (st)
        W_IDLE: begin
          if (start_prog) begin
            addr_q <= op_addr;
            data_q <= op_data;
            st     <= W_PREAD;
          end else if (start_erase) begin
            blk_q <= op_addr[AW-1:BLK_AW];
            cnt   <= '0;
            st    <= W_ERASE;
          end
        end
        W_PREAD: st <= W_PWRITE;
        W_PWRITE: begin
          prog_fail <= |(data_q & ~mem_rdata);
          cnt       <= '0;
          lim_q     <= CW'(PROG_CYCLES - 1);
          st        <= W_SETTLE;
        end
        W_ERASE: begin
          if (cnt == CW'(BLOCK_WORDS - 1)) begin
            cnt   <= '0;
            lim_q <= CW'(ERASE_EXTRA - 1);
            st    <= W_SETTLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        W_SETTLE: begin
          if (cnt == lim_q) st <= W_IDLE;
          else cnt <= cnt + 1'b1;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  always_comb begin
    busy      = (st != W_IDLE);
    mem_raddr = addr_q;
    mem_we    = (st == W_PWRITE) || (st == W_ERASE);
    if (st == W_PWRITE) begin
      mem_waddr = addr_q;
      mem_wdata = mem_rdata & data_q;
    end else begin
      mem_waddr = {blk_q, cnt[BLK_AW-1:0]};
      mem_wdata = '1;
    end
  end

  // R7/R8: the engine only leaves idle because a job was requested
  a_r7_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start_prog || start_erase));

  // R12: a deep reset aborts any job
  a_r12_abort_job: assert property (@(posedge clk) disable iff (rst)
    !hold_n |=> !busy);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int AW          = 6,
  parameter int BLK_AW      = 4,
  parameter int PROG_CYCLES = 6,
  parameter int ERASE_EXTRA = 4,
  parameter bit BOOT_AT_TOP = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          hold_n,
  input  logic          mode8,
  input  logic          lsb_a,
  input  logic [AW-1:0] addr,
  input  logic [15:0]   dq_in,
  output logic [15:0]   dq_out,
  output logic          dq_oe
);
  localparam logic [DW-1:0] DEV_CODE = BOOT_AT_TOP ? 16'h2274 : 16'h2275;

  logic          wr_q, wr_evt, rd_act;
  rmode_e        rd_mode, s1_sel;
  logic          start_prog, start_erase, clr_err, seq_err;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data;
  logic          busy, prog_fail;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr, arr_raddr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          prog_err, erase_err;
  logic [7:0]    status_byte;
  logic          s1_act, s1_a0, s1_lsb, s1_m8;
  logic [DW-1:0] id_word;

  assign wr_evt = !cs_n && wr_n && !wr_q && hold_n;
  assign rd_act = !cs_n && !rd_n && wr_n && hold_n;

  always_ff @(posedge clk) begin
    if (rst) wr_q <= 1'b1;
    else     wr_q <= wr_n;
  end

  flash_cmd_decode #(.AW(AW)) u_decode (
    .clk(clk), .rst(rst), .hold_n(hold_n), .wr_evt(wr_evt),
    .wr_addr(addr), .wr_data(dq_in), .busy(busy),
    .rd_mode(rd_mode), .start_prog(start_prog), .start_erase(start_erase),
    .op_addr(op_addr), .op_data(op_data), .clr_err(clr_err), .seq_err(seq_err)
  );

  flash_wsm #(
    .AW(AW), .BLK_AW(BLK_AW), .PROG_CYCLES(PROG_CYCLES), .ERASE_EXTRA(ERASE_EXTRA)
  ) u_wsm (
    .clk(clk), .rst(rst), .hold_n(hold_n),
    .start_prog(start_prog), .start_erase(start_erase),
    .op_addr(op_addr), .op_data(op_data), .mem_rdata(mem_rdata),
    .busy(busy), .prog_fail(prog_fail), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_raddr(mem_raddr)
  );

  assign arr_raddr = busy ? mem_raddr : addr;

  flash_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(arr_raddr), .rdata(mem_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst || !hold_n) begin
      prog_err  <= 1'b0;
      erase_err <= 1'b0;
    end else begin
      if (clr_err) begin
        prog_err  <= 1'b0;
        erase_err <= 1'b0;
      end
      if (prog_fail) prog_err  <= 1'b1;
      if (seq_err)   erase_err <= 1'b1;
    end
  end

  assign status_byte = {~busy, 1'b0, erase_err, prog_err, 4'b0000};
  assign id_word     = s1_a0 ? DEV_CODE : MFR_CODE;

  // stage 1: capture the request alongside the registered array read
  always_ff @(posedge clk) begin
    if (rst || !hold_n) begin
      s1_act <= 1'b0;
      s1_sel <= RM_ARRAY;
      s1_a0  <= 1'b0;
      s1_lsb <= 1'b0;
      s1_m8  <= 1'b0;
    end else begin
      s1_act <= rd_act;
      s1_sel <= busy ? RM_STATUS : rd_mode;
      s1_a0  <= addr[0];
      s1_lsb <= lsb_a;
      s1_m8  <= mode8;
    end
  end

  // stage 2: registered output
  always_ff @(posedge clk) begin
    if (rst || !hold_n) begin
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      dq_oe <= s1_act;
      case (s1_sel)
        RM_STATUS: dq_out <= {8'h00, status_byte};
        RM_IDENT:  dq_out <= s1_m8 ? {8'h00, id_word[7:0]} : id_word;
        default:   dq_out <= s1_m8 ? {8'h00, (s1_lsb ? mem_rdata[15:8] : mem_rdata[7:0])}
                                   : mem_rdata;
      endcase
    end
  end

  // R12: deep reset silences the bus on the next edge
  a_r12_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    !hold_n |=> !dq_oe);

  // R2: a released read strobe stops driving within two edges
  a_r2_no_drive: assert property (@(posedge clk) disable iff (rst)
    rd_n |-> ##2 !dq_oe);

  // R10: program error is sticky until cleared
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (prog_err && !clr_err && hold_n) |=> prog_err);

  // R10: erase-sequence error is sticky until cleared
  a_r10_eerr_sticky: assert property (@(posedge clk) disable iff (rst)
    (erase_err && !clr_err && hold_n) |=> erase_err);
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int AW = 6;
  localparam int WORDS = 1 << AW;
  localparam int BLK_AW = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, cs_n, rd_n, wr_n, hold_n, mode8, lsb_a, dq_oe;
  logic [AW-1:0] addr;
  logic [15:0] dq_in, dq_out;

  flash_cmd_ctrl #(.AW(AW), .BLK_AW(BLK_AW), .PROG_CYCLES(6), .ERASE_EXTRA(4),
                   .BOOT_AT_TOP(1'b1)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .hold_n(hold_n),
    .mode8(mode8), .lsb_a(lsb_a), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [15:0] mdl [WORDS];
  bit perr = 0, eerr = 0;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] stat_exp();
    return {8'h00, 1'b1, 1'b0, eerr, perr, 4'b0000};
  endfunction

  function automatic logic [15:0] arr_exp(input logic [AW-1:0] a, input bit lsb, input bit m8);
    if (!m8) return mdl[a];
    return lsb ? {8'h00, mdl[a][15:8]} : {8'h00, mdl[a][7:0]};
  endfunction

  function automatic logic [15:0] id_exp(input bit a0, input bit m8);
    logic [15:0] c;
    c = a0 ? 16'h2274 : 16'h0089;
    return m8 ? {8'h00, c[7:0]} : c;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; dq_in = d; cs_n = 0; wr_n = 0;
    @(negedge clk); wr_n = 1;
    @(negedge clk); cs_n = 1;
  endtask

  task automatic rd(input logic [AW-1:0] a, input bit lsb, input bit m8,
                    output logic [15:0] v, output logic oe);
    @(negedge clk); addr = a; lsb_a = lsb; mode8 = m8; cs_n = 0; rd_n = 0;
    repeat (2) @(negedge clk);
    v = dq_out; oe = dq_oe; cs_n = 1; rd_n = 1;
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input bit lsb,
                        input bit m8, input logic [15:0] exp);
    logic [15:0] v; logic oe;
    rd(a, lsb, m8, v, oe);
    check({tag, " drive"}, {15'd0, oe}, 16'd1);
    check(tag, v, exp);
  endtask

  task automatic wait_ready(input string tag);
    logic [15:0] v; logic oe;
    v = '0;
    for (int i = 0; i < 100; i++) begin
      rd(0, 0, 0, v, oe);
      if (v[7]) break;
    end
    check(tag, {15'd0, v[7]}, 16'd1);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [15:0] d);
    wr(a, 16'h0040);
    wr(a, d);
    wait_ready("R7 program completes");
    if ((d & ~mdl[a]) != 0) perr = 1;
    mdl[a] = mdl[a] & d;
  endtask

  task automatic erase_blk(input int b, input bit check_busy);
    logic [15:0] v; logic oe;
    wr(0, 16'h0020);
    wr(AW'(b << BLK_AW), 16'h00D0);
    if (check_busy) begin
      rd(0, 0, 0, v, oe);
      check("R9 busy erase reads status", v, {8'h00, 1'b0, 1'b0, eerr, perr, 4'b0});
    end
    wait_ready("R8 erase completes");
    for (int i = 0; i < (1 << BLK_AW); i++) mdl[(b << BLK_AW) + i] = 16'hFFFF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R9 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, d;
    logic oe;
    logic [AW-1:0] a;
    bit lsb, m8;
    logic [7:0] c;
    void'($urandom(32'd4242));
    rst = 1; cs_n = 1; rd_n = 1; wr_n = 1; hold_n = 1; mode8 = 0; lsb_a = 0;
    addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    check("R12 reset no drive", {15'd0, dq_oe}, 16'd0);
    rst = 0;

    // R8 erase every block, first one with a busy status read (R9)
    for (int b = 0; b < WORDS >> BLK_AW; b++) erase_blk(b, b == 0);
    rd_chk("R9 status sticky after erase", 3, 0, 0, stat_exp());
    wr(0, 16'h00FF);
    rd_chk("R8 erased word", 3, 0, 0, 16'hFFFF);
    rd_chk("R8 erased word top", AW'(WORDS - 1), 0, 0, 16'hFFFF);

    // R1 read array after deep reset without a command
    prog(5, 16'h1234);
    @(negedge clk); hold_n = 0;
    repeat (2) @(negedge clk); hold_n = 1;
    rd_chk("R1 array after release", 5, 0, 0, 16'h1234);

    // R2 no drive without read strobe / select
    @(negedge clk); cs_n = 0; rd_n = 1;
    repeat (2) @(negedge clk);
    check("R2 rd_n high no drive", {15'd0, dq_oe}, 16'd0);
    cs_n = 1; rd_n = 0;
    repeat (2) @(negedge clk);
    check("R2 cs_n high no drive", {15'd0, dq_oe}, 16'd0);
    rd_n = 1;

    // R3 write strobe with chip deselected is dropped
    @(negedge clk); addr = 0; dq_in = 16'h0090; cs_n = 1; wr_n = 0;
    @(negedge clk); wr_n = 1;
    rd_chk("R3 deselected write ignored", 5, 0, 0, 16'h1234);
    // R12 write while held is dropped
    @(negedge clk); hold_n = 0;
    wr(0, 16'h0090);
    @(negedge clk); hold_n = 1;
    rd_chk("R12 held write ignored", 5, 0, 0, 16'h1234);

    // R4 / R5 identifier
    wr(0, 16'h0090);
    rd_chk("R4 mfr code", 0, 0, 0, 16'h0089);
    rd_chk("R4 device code", 1, 0, 0, 16'h2274);
    rd_chk("R5 byte mfr lsb ignored", 2, 1, 1, 16'h0089);
    rd_chk("R5 byte dev", 3, 0, 1, 16'h0074);
    wr(0, 16'h0033);
    rd_chk("R11 unknown keeps ident", 1, 0, 0, 16'h2274);
    wr(0, 16'h00FF);
    rd_chk("R5 array low byte", 5, 0, 1, 16'h0034);
    rd_chk("R5 array high byte", 5, 1, 1, 16'h0012);

    // R6 / R8 / R10 status and sequence error
    wr(0, 16'h0070);
    rd_chk("R6 status idle", 0, 0, 0, 16'h0080);
    wr(0, 16'h0020); wr(0, 16'h0011); eerr = 1;
    rd_chk("R8 sequence error bit5", 0, 0, 0, 16'h00A0);
    wr(0, 16'h00FF);
    rd_chk("R8 bad sequence no erase", 5, 0, 0, 16'h1234);
    wr(0, 16'h0070);
    rd_chk("R10 error sticky", 0, 0, 0, 16'h00A0);
    wr(0, 16'h0050); eerr = 0;
    rd_chk("R10 clear", 0, 0, 0, 16'h0080);

    // R7 program only clears, error when setting bits
    prog(9, 16'h00F0);
    rd_chk("R7 status after good program", 0, 0, 0, stat_exp());
    prog(9, 16'h0F0F);
    rd_chk("R7 program error bit4", 0, 0, 0, 16'h0090);
    wr(0, 16'h00FF);
    rd_chk("R7 and result", 9, 0, 0, 16'h0000);
    wr(0, 16'h0050); perr = 0;

    // R9 writes during a job are dropped
    wr(12, 16'h0040); wr(12, 16'h5A5A);
    wr(0, 16'h00FF);
    wr(0, 16'h0090);
    wait_ready("R9 job finishes");
    mdl[12] = mdl[12] & 16'h5A5A;
    rd_chk("R9 status kept after dropped FF", 12, 0, 0, 16'h0080);
    wr(0, 16'h00FF);
    rd_chk("R9 program landed", 12, 0, 0, 16'h5A5A);

    // R12 abort mid-erase with error bit set
    wr(0, 16'h0020); wr(0, 16'h0011); eerr = 1;
    wr(0, 16'h0020); wr(AW'(16), 16'h00D0);
    rd(0, 0, 0, v, oe);
    check("R9 busy before abort", v, 16'h0020);
    @(negedge clk); hold_n = 0; cs_n = 0; rd_n = 0;
    repeat (2) @(negedge clk);
    check("R12 hold no drive", {15'd0, dq_oe}, 16'd0);
    hold_n = 1; cs_n = 1; rd_n = 1;
    eerr = 0; perr = 0;
    wr(0, 16'h0070);
    rd_chk("R12 ready and cleared after abort", 0, 0, 0, 16'h0080);
    erase_blk(1, 0);
    wr(0, 16'h00FF);

    // constrained random traffic
    for (int it = 0; it < 250; it++) begin
      a = AW'($urandom_range(0, WORDS - 1));
      lsb = 1'($urandom_range(0, 1));
      m8 = 1'($urandom_range(0, 1));
      case ($urandom_range(0, 9))
        0, 1, 2: begin
          d = 16'($urandom);
          if ($urandom_range(0, 3) != 0) d = d & mdl[a];
          prog(a, d);
          rd_chk("R7 random status", 0, 0, 0, stat_exp());
          wr(0, 16'h00FF);
          rd_chk("R7 random word", a, 0, 0, mdl[a]);
        end
        3, 4, 5: begin
          wr(0, 16'h00FF);
          rd_chk("R5 random array read", a, lsb, m8, arr_exp(a, lsb, m8));
        end
        6: begin
          wr(0, 16'h0090);
          rd_chk("R4 random ident", a, lsb, m8, id_exp(a[0], m8));
          wr(0, 16'h00FF);
        end
        7: begin
          if ($urandom_range(0, 1) == 1) begin
            wr(0, 16'h0020); wr(0, 16'h00C3); eerr = 1;
          end
          wr(0, 16'h0070);
          rd_chk("R6 random status", 0, 0, 0, stat_exp());
          if ($urandom_range(0, 1) == 1) begin
            wr(0, 16'h0050); perr = 0; eerr = 0;
            rd_chk("R10 random clear", 0, 0, 0, stat_exp());
          end
        end
        8: begin
          wr(0, 16'h00FF);
          c = 8'($urandom);
          while (c == 8'hFF || c == 8'h90 || c == 8'h70 || c == 8'h50 ||
                 c == 8'h40 || c == 8'h20) c = 8'($urandom);
          wr(a, {8'h00, c});
          rd_chk("R11 random unknown ignored", a, 0, 0, mdl[a]);
        end
        default: begin
          if ($urandom_range(0, 3) == 0) begin
            erase_blk(int'(a >> BLK_AW), 0);
            wr(0, 16'h00FF);
          end else begin
            wr(0, 16'h00FF);
          end
          rd_chk("R8 random block read", a, 0, 0, mdl[a]);
        end
      endcase
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule